// File: doc/BRIEF.md
# Byte/Word Selectable Memory Bus Interface

This block is the device-side bus front end of a parallel nonvolatile memory. It decodes three active-low strobes (chip enable `ce_n`, output enable `oe_n`, write enable `we_n`) into one of five bus operations:

- read
- write
- standby
- output-disable
- the conflicting case where output enable and write enable are both low

A width strap `byte_n` selects a 16-bit word bus or an 8-bit byte bus. In byte mode the top data pin stops being an output. It becomes the least-significant address input and chooses one half of the addressed word. The remaining upper data pins float.

The bidirectional data bus appears as three separate signals: `dq_in`, `dq_out` and a per-pin enable `dq_oe`. Read data comes from a preset internal array and leaves a register one clock after the strobes are sampled. The pin enables follow the decoded operation combinationally, so the pins are released in the same cycle a write begins. Writes never reach the array. Address and data are held in a command latch, and a one-cycle valid pulse tells a downstream state machine that a write has finished. After reset the block returns array data at once, with no command needed.

Top module: `bwmem_bus_if`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `we_n`=1 and `byte_n`=1, `dq_oe` is all ones in the same cycle. `dq_out` holds the full word at index `addr` mod 2^MEM_AW from the clock edge that sampled the read.
- R2: With `ce_n`=0, `oe_n`=1, `we_n`=0, `dq_oe` is zero. The array is not modified: a later read of the same address returns the preset word.
- R3: With `ce_n`=1, `dq_oe` is zero and no write is captured, whatever the other strobes, address and data are.
- R4: With `ce_n`=0, `oe_n`=1, `we_n`=1, `dq_oe` is zero and nothing is captured.
- R5: With `ce_n`=0 and both `oe_n` and `we_n` low, the block neither drives the bus nor captures a write.
- R6: In a read with `byte_n`=0, `dq_oe` is 16'h00FF. Pin `dq_in[15]` is the byte-select address bit: 0 puts word bits 7..0 and 1 puts word bits 15..8 on `dq_out[7:0]`, and `dq_out[15:8]` reads 0.
- R7: After reset `cmd_valid`=0, and `cmd_addr`, `cmd_lsb`, `cmd_data` and `cmd_byte` are 0. Reads return array data with no prior command.
- R8: The preset word at index i has upper byte (i+0x40) mod 256 and lower byte equal to the bitwise inverse of the low eight bits of i.
- R9: The command latch keeps the address and data of the last write cycle. In word mode `cmd_data`=`dq_in` and `cmd_lsb`=0. In byte mode `cmd_data`={8'h00, `dq_in[7:0]`}, `cmd_lsb`=`dq_in[15]` and `cmd_byte`=1.
- R10: `cmd_valid` is high for exactly one cycle. It rises at the first clock edge that samples the write operation ended. The command fields hold their values until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | Width strap: 1 word, 0 byte |
| addr | input | ADDR_W (20) | Word address |
| dq_in | input | DQ_W (16) | Data pins, input side; bit 15 is byte select in byte mode |
| dq_out | output | DQ_W (16) | Data pins, output side |
| dq_oe | output | DQ_W (16) | Per-pin output enable |
| cmd_valid | output | 1 | One-cycle pulse: a write has completed |
| cmd_addr | output | ADDR_W (20) | Latched write address |
| cmd_lsb | output | 1 | Latched byte-select bit |
| cmd_data | output | DQ_W (16) | Latched write data |
| cmd_byte | output | 1 | Latched width mode of the write |

## Verification
A wrong decode of the strobes appears at once on `dq_oe`, in the same cycle as the bad combination, so every one of the eight strobe patterns is checked in both width modes. A wrong array index or byte-lane choice appears on `dq_out` one clock after the read is sampled, so every word and every byte half of the small array is read and compared. A command latch that captures in the wrong cycle shows up as a missing or doubled `cmd_valid` pulse, or as stale fields, one edge after the write ends.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;

   // decoded bus operation from the three active-low strobes
   typedef enum logic [2:0] {
      OP_STANDBY  = 3'd0,
      OP_OUTDIS   = 3'd1,
      OP_READ     = 3'd2,
      OP_WRITE    = 3'd3,
      OP_CONFLICT = 3'd4
   } bus_op_e;

   function automatic bus_op_e decode_op(input logic ce_n, input logic oe_n,
                                         input logic we_n);
      bus_op_e op;
      if (ce_n)                op = OP_STANDBY;
      else if (!oe_n && !we_n) op = OP_CONFLICT;
      else if (!oe_n)          op = OP_READ;
      else if (!we_n)          op = OP_WRITE;
      else                     op = OP_OUTDIS;
      return op;
   endfunction

endpackage

// File: rtl/bwmem_op_decode.sv
module bwmem_op_decode
   import bwmem_pkg::*;
(
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic is_read,
   output logic is_write
);

   bus_op_e op;

   always_comb begin
      op       = decode_op(ce_n, oe_n, we_n);
      is_read  = 1'b0;
      is_write = 1'b0;
      unique case (op)
         OP_READ:  is_read  = 1'b1;
         OP_WRITE: is_write = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/bwmem_array.sv
module bwmem_array #(
   parameter int DQ_W   = 16,
   parameter int MEM_AW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [MEM_AW-1:0] idx,
   input  logic              byte_mode,
   input  logic              half_sel,
   output logic [DQ_W-1:0]   rd_q
);

   localparam int HALF  = DQ_W / 2;
   localparam int DEPTH = 1 << MEM_AW;

   logic [DQ_W-1:0] mem [DEPTH];
   logic [DQ_W-1:0] word;
   logic [HALF-1:0] lane;

   function automatic logic [DQ_W-1:0] preset_word(input int unsigned k);
      logic [HALF-1:0] hi, lo;
      hi = HALF'(k + 32'h40);
      lo = ~HALF'(k);
      return {hi, lo};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= preset_word(k);
      end
   end

   always_comb begin
      word = mem[idx];
      lane = half_sel ? word[DQ_W-1:HALF] : word[HALF-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= byte_mode ? {{HALF{1'b0}}, lane} : word;
   end

   // R6: a byte-mode read leaves the upper lane of the read register at zero
   p_byte_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && byte_mode) |=> (rd_q[DQ_W-1:HALF] == '0));

endmodule

// File: rtl/bwmem_cmd_latch.sv
module bwmem_cmd_latch #(
   parameter int ADDR_W = 20,
   parameter int DQ_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_now,
   input  logic              byte_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_lsb,
   output logic [DQ_W-1:0]   cmd_data,
   output logic              cmd_byte
);

   localparam int HALF = DQ_W / 2;

   logic wr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev   <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_addr  <= '0;
         cmd_lsb   <= 1'b0;
         cmd_data  <= '0;
         cmd_byte  <= 1'b0;
      end else begin
         wr_prev   <= wr_now;
         cmd_valid <= wr_prev && !wr_now;
         if (wr_now) begin
            cmd_addr <= addr;
            cmd_byte <= byte_mode;
            cmd_lsb  <= byte_mode & dq_in[DQ_W-1];
            cmd_data <= byte_mode ? {{HALF{1'b0}}, dq_in[HALF-1:0]} : dq_in;
         end
      end
   end

   // R10: the valid pulse lasts one cycle
   p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R10: fields hold when no write is sampled
   p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_now |=> ($stable(cmd_data) && $stable(cmd_addr) && $stable(cmd_lsb)));

   // R9: in byte mode the upper data half of the latch stays clear
   p_byte_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && byte_mode) |=> (cmd_data[DQ_W-1:HALF] == '0));

endmodule

// File: rtl/bwmem_bus_if.sv
module bwmem_bus_if #(
   parameter int ADDR_W = 20,
   parameter int DQ_W   = 16,
   parameter int MEM_AW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              byte_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic [DQ_W-1:0]   dq_oe,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_lsb,
   output logic [DQ_W-1:0]   cmd_data,
   output logic              cmd_byte
);

   localparam int HALF  = DQ_W / 2;
   localparam int LANES = 2;

   if (DQ_W % 2 != 0 || DQ_W < 4) begin : g_bad_dq
      $error("DQ_W must be even and at least 4");
   end
   if (MEM_AW < 1 || MEM_AW > 10 || MEM_AW > ADDR_W) begin : g_bad_aw
      $error("MEM_AW must lie in 1..10 and not exceed ADDR_W");
   end

   logic is_read, is_write;
   logic byte_mode;

   assign byte_mode = ~byte_n;

   bwmem_op_decode i_dec (
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .is_read  (is_read),
      .is_write (is_write)
   );

   bwmem_array #(.DQ_W(DQ_W), .MEM_AW(MEM_AW)) i_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (is_read),
      .idx       (addr[MEM_AW-1:0]),
      .byte_mode (byte_mode),
      .half_sel  (dq_in[DQ_W-1]),
      .rd_q      (dq_out)
   );

   bwmem_cmd_latch #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) i_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_now    (is_write),
      .byte_mode (byte_mode),
      .addr      (addr),
      .dq_in     (dq_in),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .cmd_lsb   (cmd_lsb),
      .cmd_data  (cmd_data),
      .cmd_byte  (cmd_byte)
   );

   // per-lane pin enables: lane 0 follows reads, lane 1 also needs word mode
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_low
         assign dq_oe[HALF-1:0] = {HALF{is_read}};
      end else begin : g_high
         assign dq_oe[DQ_W-1:HALF] = {HALF{is_read & ~byte_mode}};
      end
   end

   // R3: standby never drives
   p_standby_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (dq_oe == '0));
   // R2, R5: no drive while write enable is low
   p_no_contend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (dq_oe == '0));
   // R6: upper pins float in byte mode
   p_byte_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_n |-> (dq_oe[DQ_W-1:HALF] == '0));
   // R4: output-disable does not drive
   p_outdis_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n && we_n) |-> (dq_oe == '0));

endmodule

// File: tb/test_bwmem_bus_if.sv
`timescale 1ns/1ps
module test_bwmem_bus_if;

   localparam int ADDR_W = 20;
   localparam int DQ_W   = 16;
   localparam int MEM_AW = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              ce_n, oe_n, we_n, byte_n;
   logic [ADDR_W-1:0] addr;
   logic [DQ_W-1:0]   dq_in;
   logic [DQ_W-1:0]   dq_out, dq_oe;
   logic              cmd_valid, cmd_lsb, cmd_byte;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DQ_W-1:0]   cmd_data;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bwmem_bus_if #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .MEM_AW(MEM_AW)) i_bwmem_bus_if (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
      .dq_oe(dq_oe), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
      .cmd_lsb(cmd_lsb), .cmd_data(cmd_data), .cmd_byte(cmd_byte)
   );

   function automatic logic [15:0] exp_word(input int i);
      logic [7:0] hi, lo;
      hi = 8'(i + 64);
      lo = ~8'(i);
      return {hi, lo};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobes(input logic c, input logic o, input logic w);
      ce_n = c; oe_n = o; we_n = w;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] last_data;
      rst_n = 1'b0; strobes(1, 1, 1); byte_n = 1'b1; addr = '0; dq_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R7 reset state
      chk("R7 cmd_valid", 32'(cmd_valid), 0);
      chk("R7 cmd_data", 32'(cmd_data), 0);
      chk("R7 cmd_addr", 32'(cmd_addr), 0);
      chk("R7 cmd_lsb/byte", {30'd0, cmd_lsb, cmd_byte}, 0);
      chk("R3 standby oe", 32'(dq_oe), 0);

      // R1 R8 R7: word reads over every index, upper address bits aliased
      for (int i = 0; i < 64; i++) begin
         strobes(0, 0, 1);
         addr = ADDR_W'(i) | ADDR_W'((i * 37) << MEM_AW);
         tick();
         chk("R1 word oe", 32'(dq_oe), 32'hFFFF);
         chk("R8 word data", 32'(dq_out), 32'(exp_word(i)));
      end

      // R6: byte reads, both halves
      byte_n = 1'b0;
      for (int i = 0; i < 64; i++) begin
         for (int s = 0; s < 2; s++) begin
            addr  = ADDR_W'(i);
            dq_in = {s[0], 15'h2ABC};
            tick();
            chk("R6 byte oe", 32'(dq_oe), 32'h00FF);
            chk("R6 byte data", 32'(dq_out),
                32'(s ? exp_word(i)[15:8] : exp_word(i)[7:0]));
         end
      end

      // R3 R4 R5 R2: every strobe pattern in both widths
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < 8; c++) begin
            logic cc, oo, ww;
            bit rd, wr;
            cc = c[2]; oo = c[1]; ww = c[0];
            rd = !cc && !oo && ww;
            wr = !cc && oo && !ww;
            byte_n = m[0];
            last_data = cmd_data;
            addr  = ADDR_W'(c * 3 + 5);
            dq_in = 16'h1E50 ^ 16'(c * 16'h0101) ^ 16'(m * 16'h8000);
            strobes(cc, oo, ww);
            tick();
            if (rd) chk("R1 strobe read oe", 32'(dq_oe), m ? 32'hFFFF : 32'h00FF);
            else if (cc) chk("R3 standby oe", 32'(dq_oe), 0);
            else if (!oo && !ww) chk("R5 conflict oe", 32'(dq_oe), 0);
            else if (wr) chk("R2 write oe", 32'(dq_oe), 0);
            else chk("R4 outdis oe", 32'(dq_oe), 0);
            strobes(1, 1, 1);
            tick();
            chk(wr ? "R10 valid after write" : "R3 R4 R5 no capture",
                32'(cmd_valid), wr ? 1 : 0);
            if (wr) begin
               chk("R9 strobe data", 32'(cmd_data),
                   m ? 32'(dq_in) : {24'd0, dq_in[7:0]});
               chk("R9 strobe lsb", 32'(cmd_lsb), m ? 0 : 32'(dq_in[15]));
            end else begin
               chk("R3 R4 R5 data held", 32'(cmd_data), 32'(last_data));
            end
         end
      end

      // R2 R9 R10: word write spanning two cycles, last data wins
      byte_n = 1'b1;
      addr = 20'hA5325; dq_in = 16'h1111; strobes(0, 1, 0);
      tick();
      chk("R10 no valid during write", 32'(cmd_valid), 0);
      dq_in = 16'h1234;
      tick();
      chk("R10 no valid during write", 32'(cmd_valid), 0);
      strobes(0, 1, 1); dq_in = 16'hFFFF;
      tick();
      chk("R10 valid pulse", 32'(cmd_valid), 1);
      chk("R9 word addr", 32'(cmd_addr), 32'hA5325);
      chk("R9 word data", 32'(cmd_data), 32'h1234);
      chk("R9 word lsb/byte", {30'd0, cmd_lsb, cmd_byte}, 0);
      tick();
      chk("R10 pulse one cycle", 32'(cmd_valid), 0);
      chk("R10 fields held", 32'(cmd_data), 32'h1234);
      strobes(0, 0, 1);
      tick();
      chk("R2 array unchanged", 32'(dq_out), 32'(exp_word(6'h25)));

      // R9: byte-mode write
      byte_n = 1'b0;
      addr = 20'h00C41; dq_in = 16'h80E7; strobes(0, 1, 0);
      tick();
      strobes(1, 1, 1);
      tick();
      chk("R10 byte valid", 32'(cmd_valid), 1);
      chk("R9 byte data", 32'(cmd_data), 32'h00E7);
      chk("R9 byte lsb/byte", {30'd0, cmd_lsb, cmd_byte}, 32'h3);
      chk("R9 byte addr", 32'(cmd_addr), 32'h00C41);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule